// File: doc/BRIEF.md
# Counter-Machine Processor Core

This block is a very small programmable engine. It has four counter registers and a fixed instruction memory that a host fills through a load port. After a start pulse it fetches, decodes and executes one instruction per clock from address 0. It stops when it reaches a halt. Its only operations are clear, increment, jump, and a fused test-and-decrement: when the named register is zero that instruction branches, and otherwise it decrements the register and falls through. There is no adder, no comparator and no flag register, so every arithmetic result comes from loops built out of these primitives.

A host loads the program word by word, pulses start, and waits for the halted flag. It then reads any register through a selectable read port. The registers keep their values across halts and restarts, so a program must clear what it uses.

Top module: `ctr_machine_core`

## Requirements
- R1: An instruction word is 13 bits: opcode in bits [12:10], register index in bits [9:8], jump target in bits [7:0]. The opcodes are 0 = clear, 1 = increment, 2 = decrement-or-branch, 3 = jump and 4 = halt; opcodes 5, 6 and 7 behave as halt.
- R2: Clear writes 0 to the named register. Increment adds 1 modulo 2^16, so 0xFFFF becomes 0x0000.
- R3: Decrement-or-branch on a zero register loads the target into the PC and leaves the register at 0. On a nonzero register it subtracts 1 and advances the PC by one.
- R4: Jump loads the target into the PC. While running, exactly one instruction executes per clock and every register value matches the instruction sequence.
- R5: The halted output goes high on the cycle after a halt executes. It then stays high, with registers unchanged and readable, until the next start pulse.
- R6: A start pulse sets the PC to 0, clears halted and begins execution while keeping the register contents. If start arrives while an instruction is executing, start takes priority and that instruction has no effect.
- R7: Fetching a program address that has never been loaded since reset acts as a halt.
- R8: A doubling program with a counter of 3 that adds 2 to the target on each pass ends with 6 in the target and 0 in the counter.
- R9: A halving program with 5 in the counter ends with quotient 2 in one register, remainder 1 in another and 0 in the counter.
- R10: After reset, halted is low, all registers read 0 and nothing executes until start.
- R11: A load writes its word into the program memory. The new word is fetched from the next clock on, and a load is accepted even while the core is running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| load_en | input | 1 | Write load_word into program memory at load_addr |
| load_addr | input | 8 | Program memory address to write |
| load_word | input | 13 | Instruction word to write |
| start | input | 1 | Restart execution from address 0 |
| halted | output | 1 | High once a halt has executed, until the next start |
| rd_sel | input | 2 | Register index for the read port |
| rd_data | output | 16 | Current value of the selected register |

## Verification
Two functions can fall in the same cycle: a start pulse and the execution of a live instruction. The bench provokes this by pulsing start again during a doubling run, on exactly the edge where an increment of the target would execute. It then judges the result: the target must keep its previous value, and the run must begin again from address 0 and still finish with 6. A load that rewrites the looping jump into a halt while the core is running is the second collision, and a behavioural model followed on every clock judges it too.

// File: rtl/cm_pkg.sv
package cm_pkg;
    parameter int unsigned ADDR_W = 8;
    parameter int unsigned DATA_W = 16;
    parameter int unsigned NREG   = 4;
    parameter int unsigned OP_W   = 3;

    localparam int unsigned REG_W  = $clog2(NREG);
    localparam int unsigned WORD_W = OP_W + REG_W + ADDR_W;
    localparam int unsigned DEPTH  = 1 << ADDR_W;

    typedef enum logic [OP_W-1:0] {
        OP_CLR = 3'd0,
        OP_INC = 3'd1,
        OP_DJZ = 3'd2,
        OP_JMP = 3'd3,
        OP_HLT = 3'd4
    } op_e;

    typedef struct packed {
        logic              is_clr;
        logic              is_inc;
        logic              is_djz;
        logic              is_jmp;
        logic              is_stop;
        logic [REG_W-1:0]  idx;
        logic [ADDR_W-1:0] tgt;
    } dec_t;

    typedef struct packed {
        logic [ADDR_W-1:0] pc;
        logic              running;
        logic              halted;
    } core_st_t;
endpackage

// File: rtl/cm_progmem.sv
module cm_progmem
    import cm_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [WORD_W-1:0] wr_word,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [WORD_W-1:0] rd_word,
    output logic              rd_valid
);
    logic [WORD_W-1:0] mem_q [DEPTH];
    logic [DEPTH-1:0]  valid_d, valid_q;

    // Storage array: no reset, the valid bits qualify it.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem_q[wr_addr] <= wr_word;
        end
    end

    always_comb begin
        valid_d = valid_q;
        if (wr_en) begin
            valid_d[wr_addr] = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
        end else begin
            valid_q <= valid_d;
        end
    end

    assign rd_word  = mem_q[rd_addr];
    assign rd_valid = valid_q[rd_addr];

    // R11: a write marks its address as loaded on the next cycle
    a_r11_load_marks: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> valid_q[$past(wr_addr)]);
endmodule

// File: rtl/cm_decode.sv
module cm_decode
    import cm_pkg::*;
(
    input  logic [WORD_W-1:0] word,
    input  logic              valid,
    output dec_t              dec
);
    logic [OP_W-1:0] op;

    assign op = word[WORD_W-1 -: OP_W];

    always_comb begin
        dec         = '0;
        dec.idx     = word[ADDR_W +: REG_W];
        dec.tgt     = word[ADDR_W-1:0];
        if (!valid) begin
            dec.is_stop = 1'b1;
        end else begin
            dec.is_clr  = (op == OP_CLR);
            dec.is_inc  = (op == OP_INC);
            dec.is_djz  = (op == OP_DJZ);
            dec.is_jmp  = (op == OP_JMP);
            dec.is_stop = (op >= OP_HLT);
        end
    end

    // R1: exactly one operation class is selected per word
    always_comb begin
        a_r1_onehot_class: assert ($onehot({dec.is_clr, dec.is_inc, dec.is_djz,
                                            dec.is_jmp, dec.is_stop}) || $isunknown(word));
    end
endmodule

// File: rtl/cm_regfile.sv
module cm_regfile
    import cm_pkg::*;
(
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         we,
    input  logic [REG_W-1:0]             widx,
    input  logic [DATA_W-1:0]            wval,
    output logic [NREG-1:0][DATA_W-1:0]  regs
);
    logic [NREG-1:0][DATA_W-1:0] regs_d, regs_q;

    always_comb begin
        for (int i = 0; i < NREG; i++) begin
            regs_d[i] = regs_q[i];
            if (we && (widx == REG_W'(i))) begin
                regs_d[i] = wval;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            regs_q <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign regs = regs_q;

    // R5: without a write no register moves
    a_r5_hold_without_write: assert property (@(posedge clk) disable iff (!rst_n)
        !we |=> $stable(regs_q));
endmodule

// File: rtl/ctr_machine_core.sv
module ctr_machine_core
    import cm_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_en,
    input  logic [ADDR_W-1:0] load_addr,
    input  logic [WORD_W-1:0] load_word,
    input  logic              start,
    output logic              halted,
    input  logic [REG_W-1:0]  rd_sel,
    output logic [DATA_W-1:0] rd_data
);
    core_st_t                    st_d, st_q;
    logic [WORD_W-1:0]           fetch_word;
    logic                        fetch_valid;
    dec_t                        dec;
    logic [NREG-1:0][DATA_W-1:0] regs;
    logic [DATA_W-1:0]           cur;
    logic                        exec;
    logic                        we;
    logic [DATA_W-1:0]           wval;

    cm_progmem i_mem (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (load_en),
        .wr_addr  (load_addr),
        .wr_word  (load_word),
        .rd_addr  (st_q.pc),
        .rd_word  (fetch_word),
        .rd_valid (fetch_valid)
    );

    cm_decode i_dec (
        .word  (fetch_word),
        .valid (fetch_valid),
        .dec   (dec)
    );

    cm_regfile i_rf (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (we),
        .widx  (dec.idx),
        .wval  (wval),
        .regs  (regs)
    );

    assign cur  = regs[dec.idx];
    assign exec = st_q.running && !start;

    always_comb begin
        st_d = st_q;
        we   = 1'b0;
        wval = cur;
        if (start) begin
            st_d.pc      = '0;
            st_d.running = 1'b1;
            st_d.halted  = 1'b0;
        end else if (st_q.running) begin
            st_d.pc = st_q.pc + 1'b1;
            if (dec.is_stop) begin
                st_d.pc      = st_q.pc;
                st_d.running = 1'b0;
                st_d.halted  = 1'b1;
            end else if (dec.is_clr) begin
                we   = 1'b1;
                wval = '0;
            end else if (dec.is_inc) begin
                we   = 1'b1;
                wval = cur + 1'b1;
            end else if (dec.is_djz) begin
                if (cur == '0) begin
                    st_d.pc = dec.tgt;
                end else begin
                    we   = 1'b1;
                    wval = cur - 1'b1;
                end
            end else if (dec.is_jmp) begin
                st_d.pc = dec.tgt;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign halted  = st_q.halted;
    assign rd_data = regs[rd_sel];

    a_r2_inc_wraps: assert property (@(posedge clk) disable iff (!rst_n)
        exec && dec.is_inc |=> regs[$past(dec.idx)] == DATA_W'($past(cur) + 1'b1));

    a_r2_clr_zero: assert property (@(posedge clk) disable iff (!rst_n)
        exec && dec.is_clr |=> regs[$past(dec.idx)] == '0);

    a_r3_djz_branch: assert property (@(posedge clk) disable iff (!rst_n)
        exec && dec.is_djz && (cur == '0)
        |=> (st_q.pc == $past(dec.tgt)) && (regs[$past(dec.idx)] == '0));

    a_r3_djz_step: assert property (@(posedge clk) disable iff (!rst_n)
        exec && dec.is_djz && (cur != '0)
        |=> regs[$past(dec.idx)] == DATA_W'($past(cur) - 1'b1));

    a_r4_jmp_target: assert property (@(posedge clk) disable iff (!rst_n)
        exec && dec.is_jmp |=> st_q.pc == $past(dec.tgt));

    a_r5_halt_flag: assert property (@(posedge clk) disable iff (!rst_n)
        exec && dec.is_stop |=> halted && !st_q.running);

    a_r5_halt_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        halted && !start |=> halted && $stable(regs));

    a_r6_start_restart: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (st_q.pc == '0) && st_q.running && !halted && $stable(regs));
endmodule

// File: tb/test_ctr_machine_core.sv
`timescale 1ns/1ps
module test_ctr_machine_core;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        load_en = 1'b0;
    logic [7:0]  load_addr = '0;
    logic [12:0] load_word = '0;
    logic        start = 1'b0;
    logic        halted;
    logic [1:0]  rd_sel = '0;
    logic [15:0] rd_data;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    // behavioural reference
    int  m_mem [256];
    bit  m_val [256];
    int  m_reg [4];
    int  m_pc;
    bit  m_run;
    bit  m_halt;

    always #10 clk = ~clk;

    ctr_machine_core i_ctr_machine_core (
        .clk(clk), .rst_n(rst_n), .load_en(load_en), .load_addr(load_addr),
        .load_word(load_word), .start(start), .halted(halted),
        .rd_sel(rd_sel), .rd_data(rd_data)
    );

    function automatic logic [12:0] enc(int op, int r, int t);
        return {3'(op), 2'(r), 8'(t)};
    endfunction

    task automatic chk(bit ok, string tag, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic model_reset();
        foreach (m_val[i]) m_val[i] = 0;
        foreach (m_reg[i]) m_reg[i] = 0;
        m_pc = 0; m_run = 0; m_halt = 0;
    endtask

    task automatic model_step(bit st, bit ld, int la, int lw);
        if (st) begin
            m_pc = 0; m_run = 1; m_halt = 0;
        end else if (m_run) begin
            int w, op, r, t;
            w  = m_mem[m_pc];
            op = (w >> 10) & 7;
            r  = (w >> 8) & 3;
            t  = w & 255;
            if (!m_val[m_pc] || op >= 4) begin
                m_run = 0; m_halt = 1;
            end else if (op == 0) begin
                m_reg[r] = 0; m_pc = (m_pc + 1) % 256;
            end else if (op == 1) begin
                m_reg[r] = (m_reg[r] + 1) % 65536; m_pc = (m_pc + 1) % 256;
            end else if (op == 2) begin
                if (m_reg[r] == 0) m_pc = t;
                else begin m_reg[r] = m_reg[r] - 1; m_pc = (m_pc + 1) % 256; end
            end else begin
                m_pc = t;
            end
        end
        if (ld) begin
            m_mem[la] = lw; m_val[la] = 1;
        end
    endtask

    // compare all outputs against the model (R4 lockstep)
    task automatic compare(string tag);
        chk(halted == m_halt, {tag, " halted"}, halted, m_halt);
        for (int s = 0; s < 4; s++) begin
            rd_sel = 2'(s);
            #1;
            chk(rd_data == 16'(m_reg[s]), {tag, " reg"}, rd_data, m_reg[s]);
        end
    endtask

    // one clock; called at a negative edge
    task automatic step(bit st, bit ld, int la, int lw, string tag);
        start = st; load_en = ld; load_addr = 8'(la); load_word = 13'(lw);
        @(posedge clk);
        model_step(st, ld, la, lw);
        @(negedge clk);
        start = 0; load_en = 0;
        compare(tag);
    endtask

    task automatic load(int a, logic [12:0] w);
        step(0, 1, a, int'(w), "R11 load");
    endtask

    task automatic run_to_halt(string tag);
        for (int k = 0; k < 400 && !m_halt; k++) step(0, 0, 0, 0, tag);
    endtask

    task automatic read_reg(int s, output int v);
        rd_sel = 2'(s); #1; v = rd_data;
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL R4 watchdog actual=%0d expected=%0d", 0, 1);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin : main
        int v;
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R10: reset state, idle cycles do nothing
        compare("R10 reset");
        step(0, 0, 0, 0, "R10 idle");
        chk(halted == 0, "R10 halted low", halted, 0);

        // R7: only address 0 loaded; address 1 unloaded acts as halt
        load(0, enc(1, 0, 0));
        step(1, 0, 0, 0, "R6 start");
        step(0, 0, 0, 0, "R2 inc");
        chk(halted == 0, "R5 not yet halted", halted, 0);
        step(0, 0, 0, 0, "R7 unloaded");
        chk(halted == 1, "R7 halted", halted, 1);
        read_reg(0, v);
        chk(v == 1, "R5 reg readable after halt", v, 1);
        step(0, 0, 0, 0, "R5 sticky");
        chk(halted == 1, "R5 stays halted", halted, 1);

        // R8: doubling, with start colliding with an INC (R6)
        load(0, enc(0, 2, 0));
        for (int i = 1; i <= 3; i++) load(i, enc(1, 2, 0));
        load(4, enc(0, 1, 0));
        load(5, enc(2, 2, 9));
        load(6, enc(1, 1, 0));
        load(7, enc(1, 1, 0));
        load(8, enc(3, 0, 5));
        load(9, enc(4, 0, 0));
        step(1, 0, 0, 0, "R6 start");
        chk(halted == 0, "R6 halted cleared", halted, 0);
        for (int i = 0; i < 6; i++) step(0, 0, 0, 0, "R4 run");
        // next edge would execute INC r1 at address 6
        step(1, 0, 0, 0, "R6 collide");
        read_reg(1, v);
        chk(v == 0, "R6 start discards INC", v, 0);
        run_to_halt("R4 double");
        read_reg(1, v);
        chk(v == 6, "R8 target doubled", v, 6);
        read_reg(2, v);
        chk(v == 0, "R8 counter empty", v, 0);
        chk(halted == 1, "R5 halted after double", halted, 1);

        // R9: halving of 5, plus opcode 7 acting as halt (R1)
        load(0, enc(0, 2, 0));
        for (int i = 1; i <= 5; i++) load(i, enc(1, 2, 0));
        load(6, enc(0, 0, 0));
        load(7, enc(0, 1, 0));
        load(8, enc(2, 2, 13));
        load(9, enc(1, 1, 0));
        load(10, enc(2, 2, 13));
        load(11, enc(1, 0, 0));
        load(12, enc(3, 0, 7));
        load(13, enc(7, 3, 0));
        step(1, 0, 0, 0, "R6 start");
        run_to_halt("R3 halve");
        read_reg(0, v);
        chk(v == 2, "R9 quotient", v, 2);
        read_reg(1, v);
        chk(v == 1, "R9 remainder", v, 1);
        read_reg(2, v);
        chk(v == 0, "R3 counter stays zero", v, 0);
        chk(halted == 1, "R1 opcode 7 halts", halted, 1);

        // R2 wrap: 254 INC r3 then JMP 0; halt injected by a live load (R11)
        for (int i = 0; i < 254; i++) load(i, enc(1, 3, 0));
        load(254, enc(3, 0, 0));
        step(1, 0, 0, 0, "R6 start");
        begin
            bit seen_max = 0;
            bit wrapped = 0;
            for (int k = 0; k < 70000 && !m_halt; k++) begin
                if (seen_max && !wrapped && m_reg[3] == 0) begin
                    read_reg(3, v);
                    chk(v == 0, "R2 increment wraps", v, 0);
                    wrapped = 1;
                    step(0, 1, 254, int'(enc(4, 0, 0)), "R11 live load");
                end else begin
                    step(0, 0, 0, 0, "R4 wrap run");
                end
                if (!seen_max && m_reg[3] == 65535) begin
                    read_reg(3, v);
                    chk(v == 65535, "R2 reaches max", v, 65535);
                    seen_max = 1;
                end
            end
            chk(wrapped, "R2 wrap observed", wrapped, 1);
        end
        chk(halted == 1, "R11 loaded halt taken", halted, 1);

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule